// File: doc/BRIEF.md
# Bidirectional Split-Stream Fetch Sequencer

This block produces fetch addresses for two instruction streams that share one code block. One stream carries arithmetic and logic work (the compute stream) and the other carries control-flow and memory operations (the flow stream). A code block has a single entry and may have several exits. A taken branch names one entry address, and that address seeds both program counters. From there the compute counter climbs through memory and the flow counter descends, so the two halves of a block sit on either side of its entry point and need not have equal size.

Bundles vary in width. After each bundle its decoder reports the bundle's byte length. The sequencer moves the matching counter by that amount. Each decoder can stall its own stream. When the flow decoder meets an operation that leaves the block, the sequencer raises a one-cycle exit pulse. It then freezes both streams until the next branch arrives.

Top module: `split_fetch_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cmp_addr` and `flw_addr` both equal RESET_ADDR (default 0x1000) and `blk_exit` is 0.
- R2: When `br_valid` is high at a clock edge, both `cmp_addr` and `flw_addr` equal `br_target` after that edge. This overrides any step in the same cycle and releases an earlier freeze.
- R3: When `cmp_ready` is high and no branch or freeze applies, `cmp_addr` increases by `cmp_len` at the clock edge.
- R4: When `flw_ready` is high and no branch or freeze applies, `flw_addr` decreases by `flw_len` at the clock edge. `flw_addr` is the exclusive upper bound of the next flow bundle, which occupies bytes flw_addr-len up to flw_addr-1.
- R5: A stream whose ready input is low holds its address, whatever the other stream does. A length of zero also leaves the address unchanged.
- R6: When `flw_ready` and `flw_exit` are high and no branch or freeze applies, `blk_exit` is 1 for exactly the following cycle.
- R7: From the cycle after an exit until the next branch, both addresses hold. Ready, length and exit inputs are ignored, and `blk_exit` stays 0.
- R8: Address arithmetic wraps modulo 2^ADDR_W in both directions.
- R9: A branch in the same cycle as a flow exit marker produces no exit pulse and no freeze.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | Taken-branch pulse |
| br_target | input | ADDR_W | Block entry address |
| cmp_ready | input | 1 | Compute decoder consumed a bundle |
| cmp_len | input | LEN_W | Byte length of that compute bundle |
| flw_ready | input | 1 | Flow decoder consumed a bundle |
| flw_len | input | LEN_W | Byte length of that flow bundle |
| flw_exit | input | 1 | Flow bundle holds a block-leaving operation |
| cmp_addr | output | ADDR_W | Compute fetch address |
| flw_addr | output | ADDR_W | Flow fetch upper bound |
| blk_exit | output | 1 | One-cycle block-exit pulse |

## Verification
The bench drives a branch together with active steps on both streams. A design that lets a step win would show the target plus a length. It stalls each stream alone to catch a design that couples the two ready inputs. It walks both counters across the address wrap: a design that mishandles it would produce a wrong sign or a truncated length. It also sends an exit marker in the same cycle as a branch, and keeps stepping after an exit. A design with the wrong priority or a missing freeze would pulse on the branch, or keep advancing past the block's end.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} sfs_dir_e;
endpackage

// File: rtl/sfs_stream_pc.sv
module sfs_stream_pc #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  parameter sfs_pkg::sfs_dir_e DIR = sfs_pkg::DIR_UP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  input  logic [LEN_W-1:0]  len,
  output logic [ADDR_W-1:0] pc
);
  localparam int PAD = ADDR_W - LEN_W;

  function automatic logic [ADDR_W-1:0] widen(input logic [LEN_W-1:0] l);
    return {{PAD{1'b0}}, l};
  endfunction

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] pc_stepped;

  generate
    if (DIR == sfs_pkg::DIR_UP) begin : g_up
      assign pc_stepped = pc_q + widen(len);
    end else begin : g_down
      assign pc_stepped = pc_q - widen(len);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pc_q <= RESET_ADDR;
    else if (load)   pc_q <= load_addr;
    else if (step)   pc_q <= pc_stepped;
  end

  assign pc = pc_q;
endmodule

// File: rtl/sfs_exit_ctl.sv
module sfs_exit_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic br_valid,
  input  logic flw_ready,
  input  logic flw_exit,
  output logic frozen,
  output logic blk_exit
);
  logic frozen_q;
  logic exit_q;
  logic exit_take;

  assign exit_take = flw_ready & flw_exit & ~br_valid & ~frozen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frozen_q <= 1'b0;
      exit_q   <= 1'b0;
    end else begin
      exit_q <= exit_take;
      if (br_valid)       frozen_q <= 1'b0;
      else if (exit_take) frozen_q <= 1'b1;
    end
  end

  assign frozen   = frozen_q;
  assign blk_exit = exit_q;
endmodule

// File: rtl/split_fetch_seq.sv
module split_fetch_seq #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 6,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 32'h0000_1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              cmp_ready,
  input  logic [LEN_W-1:0]  cmp_len,
  input  logic              flw_ready,
  input  logic [LEN_W-1:0]  flw_len,
  input  logic              flw_exit,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [ADDR_W-1:0] flw_addr,
  output logic              blk_exit
);
  logic frozen;
  logic cmp_step;
  logic flw_step;

  assign cmp_step = cmp_ready & ~frozen;
  assign flw_step = flw_ready & ~frozen;

  sfs_exit_ctl u_exit (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid),
    .flw_ready(flw_ready), .flw_exit(flw_exit),
    .frozen(frozen), .blk_exit(blk_exit)
  );

  sfs_stream_pc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_ADDR(RESET_ADDR),
                  .DIR(sfs_pkg::DIR_UP)) u_cmp_pc (
    .clk(clk), .rst_n(rst_n), .load(br_valid), .load_addr(br_target),
    .step(cmp_step), .len(cmp_len), .pc(cmp_addr)
  );

  sfs_stream_pc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .RESET_ADDR(RESET_ADDR),
                  .DIR(sfs_pkg::DIR_DOWN)) u_flw_pc (
    .clk(clk), .rst_n(rst_n), .load(br_valid), .load_addr(br_target),
    .step(flw_step), .len(flw_len), .pc(flw_addr)
  );
endmodule

// File: rtl/sfs_checker.sv
module sfs_checker #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_target,
  input logic              cmp_ready,
  input logic [LEN_W-1:0]  cmp_len,
  input logic              flw_ready,
  input logic [LEN_W-1:0]  flw_len,
  input logic              flw_exit,
  input logic [ADDR_W-1:0] cmp_addr,
  input logic [ADDR_W-1:0] flw_addr,
  input logic              blk_exit,
  input logic              frozen
);
  p_branch_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> (cmp_addr == $past(br_target)) && (flw_addr == $past(br_target)));

  p_up_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && cmp_ready && !frozen) |=>
      cmp_addr == $past(cmp_addr) + ADDR_W'($past(cmp_len)));

  p_down_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && flw_ready && !frozen) |=>
      flw_addr == $past(flw_addr) - ADDR_W'($past(flw_len)));

  p_cmp_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !cmp_ready) |=> $stable(cmp_addr));

  p_flw_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !flw_ready) |=> $stable(flw_addr));

  p_exit_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    blk_exit |=> !blk_exit);

  p_frozen_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !br_valid) |=> $stable(cmp_addr) && $stable(flw_addr) && !blk_exit);

  p_branch_no_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |=> !blk_exit && !frozen);
endmodule

bind split_fetch_seq sfs_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
  .cmp_ready(cmp_ready), .cmp_len(cmp_len), .flw_ready(flw_ready),
  .flw_len(flw_len), .flw_exit(flw_exit), .cmp_addr(cmp_addr),
  .flw_addr(flw_addr), .blk_exit(blk_exit), .frozen(frozen)
);

// File: tb/split_fetch_seq_tb.sv
module split_fetch_seq_tb;
  localparam int AW = 32;
  localparam int LW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic br_valid = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic cmp_ready = 1'b0;
  logic [LW-1:0] cmp_len = '0;
  logic flw_ready = 1'b0;
  logic [LW-1:0] flw_len = '0;
  logic flw_exit = 1'b0;
  logic [AW-1:0] cmp_addr, flw_addr;
  logic blk_exit;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  split_fetch_seq u_dut (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_target(br_target),
    .cmp_ready(cmp_ready), .cmp_len(cmp_len), .flw_ready(flw_ready),
    .flw_len(flw_len), .flw_exit(flw_exit), .cmp_addr(cmp_addr),
    .flw_addr(flw_addr), .blk_exit(blk_exit)
  );

  typedef struct packed {
    logic          br;
    logic [AW-1:0] tgt;
    logic          cr;
    logic [LW-1:0] cl;
    logic          fr;
    logic [LW-1:0] fl;
    logic          fx;
    logic [AW-1:0] ec;
    logic [AW-1:0] ef;
    logic          ex;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 32'h0000_2000, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'h0000_2000, 32'h0000_2000, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd5,  1'b1, 6'd3,  1'b0, 32'h0000_2005, 32'h0000_1FFD, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd8,  1'b0, 6'd7,  1'b0, 32'h0000_200D, 32'h0000_1FFD, 1'b0},
    '{1'b0, 32'h0,         1'b0, 6'd4,  1'b1, 6'd10, 1'b0, 32'h0000_200D, 32'h0000_1FF3, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd0,  1'b1, 6'd0,  1'b0, 32'h0000_200D, 32'h0000_1FF3, 1'b0},
    '{1'b1, 32'h0000_3000, 1'b1, 6'd5,  1'b1, 6'd6,  1'b0, 32'h0000_3000, 32'h0000_3000, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd12, 1'b1, 6'd9,  1'b1, 32'h0000_300C, 32'h0000_2FF7, 1'b1},
    '{1'b0, 32'h0,         1'b1, 6'd4,  1'b1, 6'd4,  1'b0, 32'h0000_300C, 32'h0000_2FF7, 1'b0},
    '{1'b1, 32'h0000_0010, 1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 32'h0000_0010, 32'h0000_0010, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd1,  1'b1, 6'd32, 1'b0, 32'h0000_0011, 32'hFFFF_FFF0, 1'b0},
    '{1'b1, 32'hFFFF_FFFC, 1'b0, 6'd0,  1'b1, 6'd1,  1'b1, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 1'b0},
    '{1'b0, 32'h0,         1'b1, 6'd8,  1'b1, 6'd2,  1'b0, 32'h0000_0004, 32'hFFFF_FFFA, 1'b0},
    '{1'b0, 32'h0,         1'b0, 6'd0,  1'b1, 6'd0,  1'b1, 32'h0000_0004, 32'hFFFF_FFFA, 1'b1}
  };

  localparam string TAG [NV] = '{
    "R2", "R3 R4", "R5", "R5", "R5", "R2", "R6", "R7", "R2", "R8", "R9", "R8", "R6"
  };

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic br, input logic [AW-1:0] tgt, input logic cr,
                       input logic [LW-1:0] cl, input logic fr, input logic [LW-1:0] fl,
                       input logic fx);
    @(negedge clk);
    br_valid = br; br_target = tgt; cmp_ready = cr; cmp_len = cl;
    flw_ready = fr; flw_len = fl; flw_exit = fx;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string req, input logic [AW-1:0] c,
                           input logic [AW-1:0] f, input logic x);
    chk({req, " cmp_addr"}, cmp_addr, c);
    chk({req, " flw_addr"}, flw_addr, f);
    chk({req, " blk_exit"}, {31'b0, blk_exit}, {31'b0, x});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 in reset", 32'h1000, 32'h1000, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    drive(1'b0, '0, 1'b0, '0, 1'b0, '0, 1'b0);
    check_all("R1 after release", 32'h1000, 32'h1000, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].br, VEC[i].tgt, VEC[i].cr, VEC[i].cl, VEC[i].fr, VEC[i].fl, VEC[i].fx);
      check_all($sformatf("%s row %0d", TAG[i], i), VEC[i].ec, VEC[i].ef, VEC[i].ex);
    end

    // R1: reset in mid-run returns both counters to the reset address
    @(negedge clk) rst_n = 1'b0;
    #1;
    check_all("R1 mid-run reset", 32'h1000, 32'h1000, 1'b0);
    @(negedge clk) rst_n = 1'b1;

    // R6 then R7: exit, then inputs ignored while frozen
    drive(1'b1, 32'h500, 1'b0, '0, 1'b0, '0, 1'b0);
    drive(1'b0, '0, 1'b1, 6'd3, 1'b1, 6'd4, 1'b1);
    check_all("R6 exit step", 32'h503, 32'h4FC, 1'b1);
    drive(1'b0, '0, 1'b1, 6'd7, 1'b1, 6'd9, 1'b1);
    check_all("R7 frozen", 32'h503, 32'h4FC, 1'b0);
    drive(1'b0, '0, 1'b1, 6'd1, 1'b1, 6'd1, 1'b0);
    check_all("R7 still frozen", 32'h503, 32'h4FC, 1'b0);
    // R2: branch releases freeze, stepping resumes
    drive(1'b1, 32'h600, 1'b1, 6'd5, 1'b1, 6'd5, 1'b0);
    check_all("R2 release", 32'h600, 32'h600, 1'b0);
    drive(1'b0, '0, 1'b1, 6'd2, 1'b0, 6'd0, 1'b0);
    check_all("R3 resumed", 32'h602, 32'h600, 1'b0);
    drive(1'b0, '0, 1'b0, 6'd0, 1'b1, 6'd63, 1'b0);
    check_all("R4 max length", 32'h602, 32'h5C1, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule